// File: doc/BRIEF.md
# Two-Point Chirp Modulator with Segmented Slope Calibration

This block generates a frequency-chirp modulation word for a synthesizer that is modulated at two points. The same word leaves the block twice. It goes unchanged to the feedback divider path. It also goes, after a two-segment piecewise-linear predistortion, to the oscillator tuning path. When the predistortion slopes match the oscillator's actual gain in each part of its tuning range, the two injections add up to a flat response, and the chirp keeps its shape even for ramp rates above the loop bandwidth.

Each segment has its own slope. A sign-error least-mean-square loop trims the slope in the background. It multiplies the sign of the loop phase error by the modulation sample from one cycle earlier, measured inside that sample's segment. It shifts the product right by a programmable exponent and accumulates it into the slope of that segment only. The ramp sequencer produces triangular or sawtooth ramps between a start word and a stop word, with a programmable step size and a programmable idle dwell between ramps.

Top module: `tpm_cal_top`

## Requirements
- R1: While reset is asserted, div_word and osc_word are 0, and slope0 and slope1 hold their reset value of 4096, which is unity with 12 fractional bits.
- R2: div_word shows the sequencer word one clock after the word is formed. osc_word is registered on the same edge from that same word.
- R3: When the signed word n is at or below the signed breakpoint brk_word, osc_word equals floor(slope0*n/4096).
- R4: When n is above the breakpoint, osc_word equals floor((slope0*brk_word + slope1*(n-brk_word))/4096). The mapping is therefore continuous at the breakpoint.
- R5: osc_word saturates to the signed 16-bit range, 32767 to -32768, instead of wrapping.
- R6: On a clock where err_vld and cal_en are both 1 and err_in is nonzero, the slope of the segment of the previous cycle's div_word changes. The segment 0 term is that word shifted arithmetically right by step_exp. The term is added when err_in is positive and subtracted when it is negative.
- R7: For a segment 1 update, the term is (word - brk_word) shifted right by step_exp, and slope0 does not change. Both slopes never change on the same clock.
- R8: When err_in is 0, err_vld is 0 or cal_en is 0, neither slope changes.
- R9: Each slope is clamped to the range 0 to 65535.
- R10: When run rises in triangular mode (saw_mode=0), the word moves as follows. It holds start_word for one clock. It then rises by ramp_step per clock, clipped to stop_word. It then falls by ramp_step per clock, clipped to start_word. It dwells at start_word for idle_len+1 clocks, and then ramps again.
- R11: In sawtooth mode (saw_mode=1), the word stays at stop_word for one clock after it reaches it. It then returns to start_word for a dwell of idle_len+1 clocks before the next rise.
- R12: With run low, the sequencer is idle and the word is start_word from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Enables chirp generation |
| saw_mode | input | 1 | 1 selects sawtooth, 0 selects triangular |
| start_word | input | 16 | Signed low end of the ramp |
| stop_word | input | 16 | Signed high end of the ramp |
| ramp_step | input | 16 | Unsigned increment per clock |
| idle_len | input | 16 | Extra dwell clocks between ramps |
| brk_word | input | 16 | Signed predistortion breakpoint |
| cal_en | input | 1 | Enables slope adaptation |
| step_exp | input | 4 | Right-shift applied to the adaptation term |
| err_vld | input | 1 | Phase error sample valid |
| err_in | input | 12 | Signed loop phase error |
| div_word | output | 16 | Signed modulation word to the divider path |
| osc_word | output | 16 | Signed predistorted word to the oscillator path |
| slope0 | output | 16 | Segment 0 slope, 12 fractional bits |
| slope1 | output | 16 | Segment 1 slope, 12 fractional bits |

## Verification
The hardest case to reach is the one-cycle lag in the adaptation. The error must be applied to the word from the previous cycle, not to the word on the port now. The bench forces this case by changing start_word while run is low. It pulses one error sample in the single clock where div_word already shows the new value but the delayed sample still holds the old one. Only the old value gives the expected slope. The other cases are steered with idle words chosen on either side of the breakpoint, single error pulses, and breakpoints placed at 0 and near full scale. Together these reach both clamp limits and both saturation limits in a handful of clocks.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_UP   = 2'd1,
      SEQ_DOWN = 2'd2,
      SEQ_HOLD = 2'd3
   } seq_state_e;

   localparam int unsigned NSEG = 2;
endpackage

// File: rtl/tpm_chirp_seq.sv
module tpm_chirp_seq
   import tpm_pkg::*;
#(
   parameter int unsigned W  = 16,
   parameter int unsigned CW = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                saw_mode,
   input  logic signed [W-1:0] start_word,
   input  logic signed [W-1:0] stop_word,
   input  logic        [W-1:0] ramp_step,
   input  logic       [CW-1:0] idle_len,
   output logic signed [W-1:0] word_o
);
   localparam int unsigned XW = W + 2;

   seq_state_e          st_q;
   logic signed [W-1:0] w_q;
   logic       [CW-1:0] cnt_q;
   logic signed [XW-1:0] w_x, up_x, dn_x, start_x, stop_x, step_x;

   always_comb begin
      w_x     = {{2{w_q[W-1]}}, w_q};
      start_x = {{2{start_word[W-1]}}, start_word};
      stop_x  = {{2{stop_word[W-1]}}, stop_word};
      step_x  = $signed({2'b00, ramp_step});
      up_x    = w_x + step_x;
      dn_x    = w_x - step_x;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SEQ_IDLE;
         w_q   <= '0;
         cnt_q <= '0;
      end else if (!run) begin
         st_q  <= SEQ_IDLE;
         w_q   <= start_word;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            SEQ_IDLE: begin
               w_q  <= start_word;
               st_q <= SEQ_UP;
            end
            SEQ_UP: begin
               if (up_x >= stop_x) begin
                  w_q   <= stop_word;
                  cnt_q <= '0;
                  st_q  <= saw_mode ? SEQ_HOLD : SEQ_DOWN;
               end else begin
                  w_q <= up_x[W-1:0];
               end
            end
            SEQ_DOWN: begin
               if (dn_x <= start_x) begin
                  w_q   <= start_word;
                  cnt_q <= '0;
                  st_q  <= SEQ_HOLD;
               end else begin
                  w_q <= dn_x[W-1:0];
               end
            end
            default: begin
               w_q <= start_word;
               if (cnt_q == idle_len) begin
                  cnt_q <= '0;
                  st_q  <= SEQ_UP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign word_o = w_q;

   // R10: a rising ramp never moves the word downward
   assert_ramp_up_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_UP && run && stop_word >= w_q) |=> (w_q >= $past(w_q)));

   // R12: dropping run returns the sequencer to idle
   assert_run_low_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (st_q == SEQ_IDLE));
endmodule

// File: rtl/tpm_predist.sv
module tpm_predist #(
   parameter int unsigned W    = 16,
   parameter int unsigned GW   = 16,
   parameter int unsigned FRAC = 12,
   parameter bit          SAT  = 1'b1
) (
   input  logic signed [W-1:0] n_i,
   input  logic signed [W-1:0] brk_i,
   input  logic       [GW-1:0] g0_i,
   input  logic       [GW-1:0] g1_i,
   output logic signed [W-1:0] out_o
);
   localparam int unsigned PW = GW + W + 3;

   logic                  hi_seg;
   logic signed [W-1:0]   a_sel;
   logic signed [W:0]     d_raw;
   logic signed [PW-1:0]  g0x, g1x, ax, dx, p0, p1, acc, shv;

   always_comb begin
      hi_seg = n_i > brk_i;
      a_sel  = hi_seg ? brk_i : n_i;
      d_raw  = hi_seg ? ($signed({n_i[W-1], n_i}) - $signed({brk_i[W-1], brk_i})) : '0;
      g0x    = $signed({{(PW-GW){1'b0}}, g0_i});
      g1x    = $signed({{(PW-GW){1'b0}}, g1_i});
      ax     = {{(PW-W){a_sel[W-1]}}, a_sel};
      dx     = {{(PW-W-1){d_raw[W]}}, d_raw};
      p0     = g0x * ax;
      p1     = g1x * dx;
      acc    = p0 + p1;
      shv    = acc >>> FRAC;
   end

   generate
      if (SAT) begin : g_sat
         logic ovf;
         always_comb begin
            ovf = !((&shv[PW-1:W-1]) || !(|shv[PW-1:W-1]));
            if (ovf)
               out_o = shv[PW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
            else
               out_o = shv[W-1:0];
         end
      end else begin : g_wrap
         assign out_o = shv[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/tpm_slope_lms.sv
module tpm_slope_lms
   import tpm_pkg::*;
#(
   parameter int unsigned W      = 16,
   parameter int unsigned GW     = 16,
   parameter int unsigned EW     = 12,
   parameter int unsigned SW     = 4,
   parameter int unsigned G0_RST = 4096,
   parameter int unsigned G1_RST = 4096
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd_en,
   input  logic signed [EW-1:0] err_i,
   input  logic signed [W-1:0] n_i,
   input  logic signed [W-1:0] brk_i,
   input  logic       [SW-1:0] mu_i,
   output logic       [GW-1:0] g0_o,
   output logic       [GW-1:0] g1_o
);
   localparam int unsigned LW = ((GW > W + 1) ? GW : W + 1) + 2;

   logic signed [W-1:0] nd_q;
   logic                seg_hi;
   logic                err_pos, err_neg;
   logic       [GW-1:0] g_q [NSEG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nd_q <= '0;
      else        nd_q <= n_i;
   end

   always_comb begin
      seg_hi  = nd_q > brk_i;
      err_neg = err_i[EW-1];
      err_pos = !err_i[EW-1] && (|err_i);
   end

   generate
      for (genvar s = 0; s < NSEG; s++) begin : g_seg
         localparam logic [GW-1:0] RST_V = (s == 0) ? GW'(G0_RST) : GW'(G1_RST);
         logic signed [W:0]    base, shf;
         logic signed [LW-1:0] gx, dx, nxt;
         logic signed [LW-1:0] gmax;
         logic                 hit;

         always_comb begin
            if (s == 0) base = {nd_q[W-1], nd_q};
            else        base = $signed({nd_q[W-1], nd_q}) - $signed({brk_i[W-1], brk_i});
            shf  = base >>> mu_i;
            dx   = {{(LW-W-1){shf[W]}}, shf};
            gx   = $signed({{(LW-GW){1'b0}}, g_q[s]});
            gmax = $signed({{(LW-GW){1'b0}}, {GW{1'b1}}});
            nxt  = err_pos ? (gx + dx) : (gx - dx);
            hit  = upd_en && (err_pos || err_neg) && (seg_hi == (s == 1));
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               g_q[s] <= RST_V;
            end else if (hit) begin
               if (nxt < 0)          g_q[s] <= '0;
               else if (nxt > gmax)  g_q[s] <= {GW{1'b1}};
               else                  g_q[s] <= nxt[GW-1:0];
            end
         end
      end
   endgenerate

   assign g0_o = g_q[0];
   assign g1_o = g_q[1];

   // R8: without an enabled, nonzero error sample the slopes hold
   assert_slopes_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en || err_i == '0) |=> ($stable(g0_o) && $stable(g1_o)));

   // R7: at most one segment slope moves per clock
   assert_one_segment_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> !((g0_o != $past(g0_o)) && (g1_o != $past(g1_o))));
endmodule

// File: rtl/tpm_cal_top.sv
module tpm_cal_top #(
   parameter int unsigned W      = 16,
   parameter int unsigned GW     = 16,
   parameter int unsigned FRAC   = 12,
   parameter int unsigned EW     = 12,
   parameter int unsigned SW     = 4,
   parameter int unsigned CW     = 16,
   parameter int unsigned G0_RST = 4096,
   parameter int unsigned G1_RST = 4096,
   parameter bit          SAT    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 saw_mode,
   input  logic signed [W-1:0]  start_word,
   input  logic signed [W-1:0]  stop_word,
   input  logic        [W-1:0]  ramp_step,
   input  logic       [CW-1:0]  idle_len,
   input  logic signed [W-1:0]  brk_word,
   input  logic                 cal_en,
   input  logic       [SW-1:0]  step_exp,
   input  logic                 err_vld,
   input  logic signed [EW-1:0] err_in,
   output logic signed [W-1:0]  div_word,
   output logic signed [W-1:0]  osc_word,
   output logic       [GW-1:0]  slope0,
   output logic       [GW-1:0]  slope1
);
   generate
      if (W < 4)           begin : g_chk_w  $error("W must be at least 4");          end
      if (FRAC >= GW)      begin : g_chk_f  $error("FRAC must be below GW");         end
      if (EW < 2)          begin : g_chk_e  $error("EW must be at least 2");         end
      if (G0_RST >= (1 << GW) || G1_RST >= (1 << GW))
                           begin : g_chk_g  $error("reset slopes exceed GW bits");   end
   endgenerate

   logic signed [W-1:0] seq_word;
   logic signed [W-1:0] pd_word;

   tpm_chirp_seq #(.W(W), .CW(CW)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .saw_mode   (saw_mode),
      .start_word (start_word),
      .stop_word  (stop_word),
      .ramp_step  (ramp_step),
      .idle_len   (idle_len),
      .word_o     (seq_word)
   );

   tpm_predist #(.W(W), .GW(GW), .FRAC(FRAC), .SAT(SAT)) pd_i (
      .n_i   (seq_word),
      .brk_i (brk_word),
      .g0_i  (slope0),
      .g1_i  (slope1),
      .out_o (pd_word)
   );

   tpm_slope_lms #(.W(W), .GW(GW), .EW(EW), .SW(SW),
                   .G0_RST(G0_RST), .G1_RST(G1_RST)) lms_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (err_vld && cal_en),
      .err_i  (err_in),
      .n_i    (div_word),
      .brk_i  (brk_word),
      .mu_i   (step_exp),
      .g0_o   (slope0),
      .g1_o   (slope1)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_word <= '0;
         osc_word <= '0;
      end else begin
         div_word <= seq_word;
         osc_word <= pd_word;
      end
   end
endmodule

// File: tb/tpm_cal_top_tb_top.sv
`timescale 1ns/1ps
module tpm_cal_top_tb_top;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               run = 1'b0, saw_mode = 1'b0, cal_en = 1'b0, err_vld = 1'b0;
   logic signed [15:0] start_word = '0, stop_word = '0, brk_word = '0;
   logic        [15:0] ramp_step = '0, idle_len = '0;
   logic        [3:0]  step_exp = '0;
   logic signed [11:0] err_in = '0;
   logic signed [15:0] div_word, osc_word;
   logic        [15:0] slope0, slope1;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tpm_cal_top dut_i (
      .clk(clk), .rst_n(rst_n), .run(run), .saw_mode(saw_mode),
      .start_word(start_word), .stop_word(stop_word), .ramp_step(ramp_step),
      .idle_len(idle_len), .brk_word(brk_word), .cal_en(cal_en),
      .step_exp(step_exp), .err_vld(err_vld), .err_in(err_in),
      .div_word(div_word), .osc_word(osc_word), .slope0(slope0), .slope1(slope1)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; run = 1'b0; saw_mode = 1'b0; cal_en = 1'b1; err_vld = 1'b0;
      err_in = '0; start_word = '0; stop_word = '0; brk_word = '0;
      ramp_step = '0; idle_len = '0; step_exp = '0;
      clocks(2);
      rst_n = 1'b1;
   endtask

   task automatic pulse_err(input logic signed [11:0] e);
      err_vld = 1'b1; err_in = e;
      @(posedge clk); @(negedge clk);
      err_vld = 1'b0; err_in = '0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 div", div_word, 0);
      chk("R1 osc", osc_word, 0);
      chk("R1 slope0", slope0, 4096);
      chk("R1 slope1", slope1, 4096);
      rst_n = 1'b1;
   endtask

   task automatic t_unity();
      do_reset();
      brk_word = 16'sd2000; start_word = 16'sd1234;
      clocks(4);
      chk("R2 div", div_word, 1234);
      chk("R3 osc unity", osc_word, 1234);
      start_word = -16'sd800;
      clocks(2);
      chk("R2 div neg", div_word, -800);
      chk("R3 osc unity neg", osc_word, -800);
   endtask

   task automatic t_segments();
      do_reset();
      brk_word = 16'sd2000; start_word = 16'sd1000; step_exp = 4'd2;
      clocks(4);
      pulse_err(12'sd5);
      chk("R6 slope0 up", slope0, 4346);
      chk("R7 slope1 untouched", slope1, 4096);
      clocks(1);
      chk("R3 osc seg0", osc_word, 1061);
      start_word = 16'sd3000;
      clocks(4);
      pulse_err(-12'sd3);
      chk("R7 slope1 down", slope1, 3846);
      chk("R7 slope0 untouched", slope0, 4346);
      clocks(1);
      chk("R4 osc seg1", osc_word, 3061);
      start_word = 16'sd2000;
      clocks(2);
      chk("R4 osc at breakpoint", osc_word, 2122);
      start_word = 16'sd2001;
      clocks(2);
      chk("R4 osc just above", osc_word, 2123);
      start_word = -16'sd800;
      clocks(2);
      chk("R3 osc negative floor", osc_word, -849);
   endtask

   task automatic t_delay();
      do_reset();
      brk_word = 16'sd2000; start_word = 16'sd1000;
      clocks(5);
      start_word = 16'sd1500;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R6 div moved", div_word, 1500);
      pulse_err(12'sd1);
      chk("R6 uses previous word", slope0, 5096);
   endtask

   task automatic t_no_update();
      do_reset();
      brk_word = 16'sd2000; start_word = 16'sd1000;
      clocks(4);
      pulse_err(12'sd0);
      chk("R8 zero error", slope0, 4096);
      err_in = 12'sd7; err_vld = 1'b0;
      clocks(2);
      chk("R8 not valid", slope0, 4096);
      cal_en = 1'b0;
      pulse_err(12'sd7);
      chk("R8 cal disabled", slope0, 4096);
      chk("R8 slope1", slope1, 4096);
      clocks(1);
      chk("R8 osc kept", osc_word, 1000);
   endtask

   task automatic t_clamp();
      do_reset();
      brk_word = 16'sd2000; start_word = 16'sd32000;
      clocks(4);
      pulse_err(-12'sd1);
      chk("R9 floor", slope1, 0);
      clocks(1);
      chk("R4 osc flat", osc_word, 2000);
      brk_word = 16'sd30000; start_word = 16'sd30000;
      clocks(4);
      pulse_err(12'sd1);
      chk("R6 slope0 step", slope0, 34096);
      pulse_err(12'sd1);
      pulse_err(12'sd1);
      chk("R9 ceiling", slope0, 65535);
   endtask

   task automatic t_sat();
      do_reset();
      brk_word = 16'sd0; start_word = 16'sd30000;
      clocks(4);
      pulse_err(12'sd1);
      chk("R7 slope1 big", slope1, 34096);
      clocks(1);
      chk("R5 positive saturation", osc_word, 32767);
      start_word = -16'sd30000;
      clocks(4);
      pulse_err(-12'sd1);
      chk("R6 slope0 negative word", slope0, 34096);
      clocks(1);
      chk("R5 negative saturation", osc_word, -32768);
   endtask

   task automatic t_tri();
      int exp_seq [14] = '{0, 0, 30, 60, 90, 100, 70, 40, 10, 0, 0, 0, 0, 30};
      do_reset();
      start_word = 16'sd0; stop_word = 16'sd100; ramp_step = 16'd30; idle_len = 16'd2;
      saw_mode = 1'b0; brk_word = 16'sd1000;
      clocks(3);
      run = 1'b1;
      for (int i = 0; i < 14; i++) begin
         clocks(1);
         chk($sformatf("R10 tri step %0d", i), div_word, exp_seq[i]);
      end
   endtask

   task automatic t_saw();
      int exp_seq [7] = '{0, 0, 40, 80, 100, 0, 40};
      do_reset();
      start_word = 16'sd0; stop_word = 16'sd100; ramp_step = 16'd40; idle_len = 16'd0;
      saw_mode = 1'b1; brk_word = 16'sd1000;
      clocks(3);
      run = 1'b1;
      for (int i = 0; i < 7; i++) begin
         clocks(1);
         chk($sformatf("R11 saw step %0d", i), div_word, exp_seq[i]);
      end
      run = 1'b0;
      clocks(2);
      chk("R12 back to start", div_word, 0);
      clocks(3);
      chk("R12 stays idle", div_word, 0);
   endtask

   initial begin
      t_reset();
      t_unity();
      t_segments();
      t_delay();
      t_no_update();
      t_clamp();
      t_sat();
      t_tri();
      t_saw();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule